// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Bid Generator

This block sits in one serial channel and builds the values that the channel presents to a shared interrupt arbiter. It produces one bid for the receive path, one for the transmit path, and one for each of four event sources. The arbiter compares these bids as unsigned numbers, so a larger bid wins. The FIFOs and the arbiter are outside this block.

The receive bid holds the receive FIFO's character count in its upper bits, so the bid rises as the FIFO fills. The transmit bid holds the transmit FIFO's count of free slots in its upper bits, so the bid rises as the FIFO drains. Each path has a 2-bit trigger select. A path does not bid until its count reaches the selected threshold.

Each event source has the following:
- a set pulse from its detector, which makes it pending;
- a clear pulse from the register interface, which removes the pending state;
- an enable;
- a programmable 5-bit priority field that forms the upper bits of its bid.

All bids share one layout. Bits 9..5 hold the count or the priority, bits 4..3 hold a type code, and bits 2..0 hold the channel number.

Top module: `irq_bid_gen`

## Requirements
- R1: While the receive path is active, rx_bid_o equals {rx count (5 bits), type code 2'b11, chan_i}. While it is inactive, rx_bid_o is zero.
- R2: While the transmit path is active, tx_bid_o equals {tx free count (5 bits), type code 2'b10, chan_i}. While it is inactive, tx_bid_o is zero.
- R3: With rx_en_i high, rx_active_o is high exactly when the rx count is at least the threshold selected by rx_level_i. The codes 0, 1, 2 and 3 select thresholds of 1, 8, 12 and 16 characters.
- R4: With tx_en_i high, tx_active_o is high exactly when the tx free count is at least the threshold selected by tx_level_i. The codes are the same as in R3: 0→1, 1→8, 2→12, 3→16 free slots.
- R5: A count input above 16 is treated as 16, both in the threshold test and in the bid.
- R6: When rx_en_i is low, rx_active_o is low and rx_bid_o is zero. When tx_en_i is low, the same holds for tx_active_o and tx_bid_o.
- R7: A one-cycle pulse on evt_set_i[k] makes source k pending from the next clock edge. Source k stays pending until it is cleared.
- R8: A pulse on evt_clr_i[k] removes the pending state at the next edge. If set and clear arrive in the same cycle, set wins.
- R9: While event source k is active, its 10-bit slice of evt_bid_o equals {evt_prio_i slice k, type code k (2 bits), chan_i}. Slice k occupies bits 10k+9..10k. While source k is inactive, its slice is zero.
- R10: evt_active_o[k] equals pending AND evt_en_i[k]. A low enable hides a pending source without discarding its pending state.
- R11: After reset, no event source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_i | input | 3 | Channel number placed in every bid |
| rx_count_i | input | 5 | Characters held in the receive FIFO |
| rx_level_i | input | 2 | Receive trigger select |
| rx_en_i | input | 1 | Receive interrupt enable |
| tx_free_i | input | 5 | Free slots in the transmit FIFO |
| tx_level_i | input | 2 | Transmit trigger select |
| tx_en_i | input | 1 | Transmit interrupt enable |
| evt_set_i | input | 4 | Per-source event pulse |
| evt_clr_i | input | 4 | Per-source clear pulse |
| evt_en_i | input | 4 | Per-source enable |
| evt_prio_i | input | 20 | Per-source 5-bit priority field, source k in bits 5k+4..5k |
| rx_active_o | output | 1 | Receive path is bidding |
| rx_bid_o | output | 10 | Receive bid |
| tx_active_o | output | 1 | Transmit path is bidding |
| tx_bid_o | output | 10 | Transmit bid |
| evt_active_o | output | 4 | Per-source active flag |
| evt_bid_o | output | 40 | Per-source bids, 10 bits each |

## Verification
The bench sets each trigger code with counts just below and exactly at the threshold. An off-by-one compare would start bidding one character early or late, and would show up there. It drives counts of 17 and 31 to catch a missing clamp, which would give an oversized bid or truncated upper bits. It pulses set and clear in the same cycle to catch a design that drops the event. It also toggles an event's enable while the event is pending, to catch a design that discards the event instead of only hiding it.

// File: rtl/ibid_pkg.sv
package ibid_pkg;
  typedef enum logic [1:0] {
    LVL_ANY  = 2'd0,
    LVL_HALF = 2'd1,
    LVL_3Q   = 2'd2,
    LVL_ALL  = 2'd3
  } trig_lvl_e;

  localparam logic [1:0] TYPE_RX = 2'b11;
  localparam logic [1:0] TYPE_TX = 2'b10;

  function automatic int lvl_threshold(input logic [1:0] lvl, input int depth);
    case (trig_lvl_e'(lvl))
      LVL_ANY:  return 1;
      LVL_HALF: return depth / 2;
      LVL_3Q:   return (depth * 3) / 4;
      default:  return depth;
    endcase
  endfunction
endpackage

// File: rtl/fifo_bid.sv
module fifo_bid #(
  parameter int         DEPTH = 16,
  parameter int         CH_W  = 3,
  parameter logic [1:0] TYPE  = 2'b11,
  localparam int        CNT_W = $clog2(DEPTH + 1),
  localparam int        BID_W = CNT_W + 2 + CH_W
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       lvl_i,
  input  logic             en_i,
  input  logic [CH_W-1:0]  chan_i,
  output logic             active_o,
  output logic [BID_W-1:0] bid_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] sat_cnt;
  logic [CNT_W-1:0] thr;

  always_comb begin
    sat_cnt  = (cnt_i > MAX_CNT) ? MAX_CNT : cnt_i;
    thr      = CNT_W'(ibid_pkg::lvl_threshold(lvl_i, DEPTH));
    active_o = en_i && (sat_cnt >= thr);
    bid_o    = active_o ? {sat_cnt, TYPE, chan_i} : '0;
  end
endmodule

// File: rtl/event_bid.sv
module event_bid #(
  parameter int         PRIO_W = 5,
  parameter int         CH_W   = 3,
  parameter logic [1:0] TYPE   = 2'b00,
  localparam int        BID_W  = PRIO_W + 2 + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic              active_o,
  output logic [BID_W-1:0]  bid_o
);
  logic pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pending_q <= 1'b0;
    else if (set_i)  pending_q <= 1'b1;
    else if (clr_i)  pending_q <= 1'b0;
  end

  assign active_o = pending_q && en_i;
  assign bid_o    = active_o ? {prio_i, TYPE, chan_i} : '0;

  assert_set_pends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && en_i) |=> active_o || !en_i);
  assert_set_beats_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> pending_q);
  assert_clr_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !active_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !clr_i) |=> pending_q);
  assert_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (bid_o == '0));
endmodule

// File: rtl/irq_bid_gen.sv
module irq_bid_gen #(
  parameter int  DEPTH   = 16,
  parameter int  CH_W    = 3,
  parameter int  NUM_EVT = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int BID_W   = CNT_W + 2 + CH_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CH_W-1:0]          chan_i,
  input  logic [CNT_W-1:0]         rx_count_i,
  input  logic [1:0]               rx_level_i,
  input  logic                     rx_en_i,
  input  logic [CNT_W-1:0]         tx_free_i,
  input  logic [1:0]               tx_level_i,
  input  logic                     tx_en_i,
  input  logic [NUM_EVT-1:0]       evt_set_i,
  input  logic [NUM_EVT-1:0]       evt_clr_i,
  input  logic [NUM_EVT-1:0]       evt_en_i,
  input  logic [NUM_EVT*CNT_W-1:0] evt_prio_i,
  output logic                     rx_active_o,
  output logic [BID_W-1:0]         rx_bid_o,
  output logic                     tx_active_o,
  output logic [BID_W-1:0]         tx_bid_o,
  output logic [NUM_EVT-1:0]       evt_active_o,
  output logic [NUM_EVT*BID_W-1:0] evt_bid_o
);
  fifo_bid #(.DEPTH(DEPTH), .CH_W(CH_W), .TYPE(ibid_pkg::TYPE_RX)) u_rx (
    .cnt_i(rx_count_i), .lvl_i(rx_level_i), .en_i(rx_en_i), .chan_i(chan_i),
    .active_o(rx_active_o), .bid_o(rx_bid_o)
  );

  fifo_bid #(.DEPTH(DEPTH), .CH_W(CH_W), .TYPE(ibid_pkg::TYPE_TX)) u_tx (
    .cnt_i(tx_free_i), .lvl_i(tx_level_i), .en_i(tx_en_i), .chan_i(chan_i),
    .active_o(tx_active_o), .bid_o(tx_bid_o)
  );

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    event_bid #(.PRIO_W(CNT_W), .CH_W(CH_W), .TYPE(2'(k))) u_evt (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(evt_set_i[k]), .clr_i(evt_clr_i[k]), .en_i(evt_en_i[k]),
      .prio_i(evt_prio_i[k*CNT_W +: CNT_W]), .chan_i(chan_i),
      .active_o(evt_active_o[k]), .bid_o(evt_bid_o[k*BID_W +: BID_W])
    );
  end

  assert_rx_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> !rx_active_o && rx_bid_o == '0);
  assert_tx_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !tx_active_o && tx_bid_o == '0);
  assert_rx_nonzero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_o |-> rx_bid_o[BID_W-1 -: CNT_W] != '0 && rx_bid_o[CH_W +: 2] == 2'b11);
  assert_tx_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_o |-> tx_bid_o[BID_W-1 -: CNT_W] != '0 && tx_bid_o[CH_W +: 2] == 2'b10);
  assert_rx_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_active_o |-> rx_bid_o[BID_W-1 -: CNT_W] <= CNT_W'(DEPTH));
  assert_tx_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_o |-> tx_bid_o[BID_W-1 -: CNT_W] <= CNT_W'(DEPTH));
endmodule

// File: tb/irq_bid_gen_bench.sv
module irq_bid_gen_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  chan = 3'd5;
  logic [4:0]  rx_count = 0, tx_free = 0;
  logic [1:0]  rx_level = 0, tx_level = 0;
  logic        rx_en = 0, tx_en = 0;
  logic [3:0]  evt_set = 0, evt_clr = 0, evt_en = 0;
  logic [19:0] evt_prio = 0;
  logic        rx_active, tx_active;
  logic [9:0]  rx_bid, tx_bid;
  logic [3:0]  evt_active;
  logic [39:0] evt_bid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_bid_gen u_irq_bid_gen (
    .clk_i(clk), .rst_ni(rst_n), .chan_i(chan),
    .rx_count_i(rx_count), .rx_level_i(rx_level), .rx_en_i(rx_en),
    .tx_free_i(tx_free), .tx_level_i(tx_level), .tx_en_i(tx_en),
    .evt_set_i(evt_set), .evt_clr_i(evt_clr), .evt_en_i(evt_en), .evt_prio_i(evt_prio),
    .rx_active_o(rx_active), .rx_bid_o(rx_bid), .tx_active_o(tx_active), .tx_bid_o(tx_bid),
    .evt_active_o(evt_active), .evt_bid_o(evt_bid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int thr_of(input int lvl);
    return (lvl == 0) ? 1 : (lvl == 1) ? 8 : (lvl == 2) ? 12 : 16;
  endfunction

  function automatic logic [9:0] fbid(input int cnt, input logic [1:0] ty, input logic [2:0] ch);
    int s = (cnt > 16) ? 16 : cnt;
    return {5'(s), ty, ch};
  endfunction

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R11 events idle after reset", evt_active, 4'h0);
    chk("R11 event bids zero after reset", evt_bid, 40'h0);
    chk("R6 rx masked", {rx_active, rx_bid}, 11'h0);
  endtask

  task automatic t_rx_levels();
    rx_en = 1;
    for (int l = 0; l < 4; l++) begin
      rx_level = 2'(l);
      for (int d = -1; d <= 0; d++) begin
        int c = thr_of(l) + d;
        @(negedge clk); rx_count = 5'(c); #1;
        chk("R3 rx active at level", rx_active, (c >= thr_of(l)));
        chk("R1 rx bid", rx_bid, (c >= thr_of(l)) ? fbid(c, 2'b11, chan) : 10'h0);
      end
    end
  endtask

  task automatic t_tx_levels();
    tx_en = 1;
    chan = 3'd2;
    for (int l = 0; l < 4; l++) begin
      tx_level = 2'(l);
      for (int d = -1; d <= 0; d++) begin
        int c = thr_of(l) + d;
        @(negedge clk); tx_free = 5'(c); #1;
        chk("R4 tx active at level", tx_active, (c >= thr_of(l)));
        chk("R2 tx bid", tx_bid, (c >= thr_of(l)) ? fbid(c, 2'b10, chan) : 10'h0);
      end
    end
  endtask

  task automatic t_clamp();
    @(negedge clk); rx_level = 2'd3; tx_level = 2'd3; rx_count = 5'd17; tx_free = 5'd31; #1;
    chk("R5 rx clamp active", rx_active, 1'b1);
    chk("R5 rx clamp bid", rx_bid, fbid(16, 2'b11, chan));
    chk("R5 tx clamp bid", tx_bid, fbid(16, 2'b10, chan));
  endtask

  task automatic t_mask_fifo();
    @(negedge clk); rx_en = 0; tx_en = 0; rx_level = 0; tx_level = 0; #1;
    chk("R6 rx disabled", {rx_active, rx_bid}, 11'h0);
    chk("R6 tx disabled", {tx_active, tx_bid}, 11'h0);
  endtask

  task automatic t_events();
    evt_prio = {5'd3, 5'd31, 5'd0, 5'd17};
    evt_en = 4'hF;
    @(negedge clk); evt_set = 4'b0101;
    @(negedge clk); evt_set = 0; #1;
    chk("R7 events pending", evt_active, 4'b0101);
    chk("R9 event 0 bid", evt_bid[9:0], {5'd17, 2'd0, chan});
    chk("R9 event 2 bid", evt_bid[29:20], {5'd31, 2'd2, chan});
    chk("R9 idle event 1 bid zero", evt_bid[19:10], 10'h0);
    repeat (3) @(negedge clk); #1;
    chk("R7 events held", evt_active, 4'b0101);
    @(negedge clk); evt_clr = 4'b0001;
    @(negedge clk); evt_clr = 0; #1;
    chk("R8 clear drops source 0", evt_active, 4'b0100);
    @(negedge clk); evt_set = 4'b1000; evt_clr = 4'b1100;
    @(negedge clk); evt_set = 0; evt_clr = 0; #1;
    chk("R8 set beats clear", evt_active, 4'b1000);
    chk("R9 event 3 bid", evt_bid[39:30], {5'd3, 2'd3, chan});
  endtask

  task automatic t_event_mask();
    @(negedge clk); evt_en = 4'b0111; #1;
    chk("R10 masked source hidden", evt_active, 4'b0000);
    chk("R10 masked bid zero", evt_bid[39:30], 10'h0);
    @(negedge clk); evt_set = 4'b0010; evt_en = 4'b0000;
    @(negedge clk); evt_set = 0; #1;
    chk("R10 disabled set not visible", evt_active, 4'b0000);
    @(negedge clk); evt_en = 4'hF; #1;
    chk("R10 pending kept while masked", evt_active, 4'b1010);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rx_levels();
    t_tx_levels();
    t_clamp();
    t_mask_fifo();
    t_events();
    t_event_mask();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule